// File: doc/BRIEF.md
# Warp Load Coalescer

This block sits between a group of 32 lanes and the memory system. Each load request holds one byte address per lane, with an active bit for each lane. The block splits the request into the fewest aligned line transactions that cover every active address. Lanes whose words fall in the same 128-byte line share one transaction. Each line is divided into four 32-byte sectors, and a transaction asks only for the sectors that hold a requested word. It is sized at 32, 64 or 128 bytes, whichever is the smallest that covers those sectors.

Transactions leave one per cycle over a valid/ready handshake. Each one carries the line address, the sector mask, the size code and the mask of the lanes it serves. The order follows the lowest-numbered lane that has not yet been served. After the final transaction has been accepted, a one-cycle done pulse reports how many transactions and sectors the request needed. The request port stays closed until that point.

Top module: `warp_coalescer`

## Requirements
- R1: `reqReady` is high whenever no request is being served. A request is taken on a cycle where `reqValid` and `reqReady` are both high. `reqReady` then stays low until the done pulse of that request.
- R2: Each transaction serves exactly those pending active lanes whose address bits [31:7] match the line of the lowest-numbered pending lane. `txnLineAddr` is that line with bits [6:0] at zero. Bit i of `txnLanes` stands for lane i. Address bits [1:0] are ignored.
- R3: The transactions of a request are emitted in order of increasing lowest-numbered pending lane, and each active lane is served exactly once.
- R4: Bit s of `txnSectors` is set exactly when a served lane has address bits [6:5] equal to s.
- R5: `txnSize` is 0 (32 bytes) when one sector is set. It is 1 (64 bytes) when all set sectors lie within {0,1} or within {2,3}. It is 2 (128 bytes) otherwise.
- R6: Inactive lanes are ignored. They appear in no `txnLanes` mask and add to no count.
- R7: A request with no active lanes produces no transaction. Its done pulse reports zero transactions and zero sectors.
- R8: While `txnValid` is high and `txnReady` is low, every transaction output holds its value into the next cycle.
- R9: `doneValid` is high for exactly one cycle, the cycle after the final transaction is accepted. During that cycle `doneTxnCount` (6 bits) holds the number of transactions. `doneSectorCount` (7 bits) holds the sum of the set sector bits over all transactions.
- R10: These patterns give fixed results:
  - 32 consecutive words from a 128-byte-aligned base give one transaction with four sectors.
  - The same words from an unaligned base give two transactions.
  - A broadcast gives one transaction with one sector.
  - A stride of at least one line per lane gives 32 one-sector transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqActive | input | 32 | Active bit per lane |
| reqAddr | input | 1024 | Byte addresses, lane i at bits [32i+31:32i] |
| txnValid | output | 1 | Transaction present |
| txnReady | input | 1 | Memory side accepts the transaction |
| txnLineAddr | output | 32 | 128-byte-aligned line address |
| txnSectors | output | 4 | Sectors fetched |
| txnSize | output | 2 | 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txnLanes | output | 32 | Lanes served by the transaction |
| doneValid | output | 1 | One-cycle completion pulse |
| doneTxnCount | output | 6 | Transactions in the finished request |
| doneSectorCount | output | 7 | Sectors in the finished request |

## Verification
The directed cases each expose a specific fault:
- An aligned contiguous request shows a design that splits one line into two transactions.
- A request starting 64 bytes into a line shows a design that ignores the line boundary and emits a single transaction.
- A broadcast shows a design that counts one sector per lane instead of one per distinct sector.
- A large stride shows a design that merges lanes across different lines.
- A request with no active lanes shows a design that hangs or reports a non-zero count.
- A half-active request whose inactive lanes point at distinct lines shows a design that issues transactions for lanes that are switched off.

Random stall patterns on `txnReady` show any transaction that changes or is skipped under back-pressure. Random clustered addresses then compare every transaction's lanes, sectors and size against a bench model.

// File: rtl/warp_coalescer_pkg.sv
package warp_coalescer_pkg;
  typedef struct packed {
    logic load;
    logic retire;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } txnSize_e;
endpackage

// File: rtl/warp_coalescer_ctrl.sv
module warp_coalescer_ctrl
  import warp_coalescer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        txnReady,
  input  logic        pendingEmpty,
  input  logic        lastTxn,
  output logic        reqReady,
  output logic        txnValid,
  output logic        doneValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_BUSY} ctrlState_e;

  ctrlState_e stateQ;
  logic       doneQ;

  always_comb begin
    reqReady      = (stateQ == ST_IDLE);
    txnValid      = (stateQ == ST_BUSY) && !pendingEmpty;
    strobe.load   = reqReady && reqValid;
    strobe.retire = txnValid && txnReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: if (strobe.load) stateQ <= ST_BUSY;
        ST_BUSY: begin
          if (pendingEmpty || (strobe.retire && lastTxn)) begin
            doneQ  <= 1'b1;
            stateQ <= ST_IDLE;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign doneValid = doneQ;
endmodule

// File: rtl/warp_coalescer_dp.sv
module warp_coalescer_dp
  import warp_coalescer_pkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  localparam int LINE_LSB    = $clog2(LINE_BYTES),
  localparam int SECT_LSB    = $clog2(SECTOR_BYTES),
  localparam int SECT_NUM    = LINE_BYTES / SECTOR_BYTES,
  localparam int LANE_W      = $clog2(LANES),
  localparam int TXN_CNT_W   = LANE_W + 1,
  localparam int SEC_CNT_W   = LANE_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [LANES-1:0]        reqActive,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  output logic                    pendingEmpty,
  output logic                    lastTxn,
  output logic [ADDR_W-1:0]       txnLineAddr,
  output logic [SECT_NUM-1:0]     txnSectors,
  output logic [1:0]              txnSize,
  output logic [LANES-1:0]        txnLanes,
  output logic [TXN_CNT_W-1:0]    txnCount,
  output logic [SEC_CNT_W-1:0]    sectorCount
);
  localparam int KEEP_W = ADDR_W - SECT_LSB;
  localparam int LINE_W = ADDR_W - LINE_LSB;
  localparam int SECT_W = LINE_LSB - SECT_LSB;

  logic [KEEP_W-1:0]    addrQ [LANES];
  logic [LANES-1:0]     pendingQ;
  logic [TXN_CNT_W-1:0] txnCntQ;
  logic [SEC_CNT_W-1:0] secCntQ;

  logic [LANE_W-1:0]    leaderIdx;
  logic [LINE_W-1:0]    leaderLine;
  logic [LANES-1:0]     matchVec;
  logic [SECT_NUM-1:0]  sectHot [LANES];
  logic [SECT_NUM-1:0]  sectMask;
  logic [LANES*SECT_LSB-1:0] lowBits;
  logic                 unusedLowBits;

  // Lowest pending lane leads the next transaction
  always_comb begin
    leaderIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pendingQ[i]) leaderIdx = LANE_W'(i);
    end
  end

  assign leaderLine = addrQ[leaderIdx][KEEP_W-1:SECT_W];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign matchVec[g] = pendingQ[g] && (addrQ[g][KEEP_W-1:SECT_W] == leaderLine);
    assign sectHot[g]  = matchVec[g] ? (SECT_NUM'(1) << addrQ[g][SECT_W-1:0]) : '0;
    assign lowBits[g*SECT_LSB +: SECT_LSB] = reqAddr[g*ADDR_W +: SECT_LSB];
  end
  assign unusedLowBits = ^lowBits;

  always_comb begin
    sectMask = '0;
    for (int i = 0; i < LANES; i++) sectMask = sectMask | sectHot[i];
  end

  function automatic logic [1:0] pickSize(input logic [SECT_NUM-1:0] m);
    if ($countones(m) <= 1)
      return SZ_32;
    else if (m[SECT_NUM-1:SECT_NUM/2] == '0 || m[SECT_NUM/2-1:0] == '0)
      return SZ_64;
    else
      return SZ_128;
  endfunction

  assign txnLineAddr  = {leaderLine, {LINE_LSB{1'b0}}};
  assign txnSectors   = sectMask;
  assign txnSize      = pickSize(sectMask);
  assign txnLanes     = matchVec;
  assign pendingEmpty = (pendingQ == '0);
  assign lastTxn      = ((pendingQ & ~matchVec) == '0);
  assign txnCount     = txnCntQ;
  assign sectorCount  = secCntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= '0;
      txnCntQ  <= '0;
      secCntQ  <= '0;
    end else if (strobe.load) begin
      pendingQ <= reqActive;
      txnCntQ  <= '0;
      secCntQ  <= '0;
    end else if (strobe.retire) begin
      pendingQ <= pendingQ & ~matchVec;
      txnCntQ  <= txnCntQ + 1'b1;
      secCntQ  <= secCntQ + SEC_CNT_W'($countones(sectMask));
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int i = 0; i < LANES; i++)
        addrQ[i] <= reqAddr[i*ADDR_W + SECT_LSB +: KEEP_W];
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import warp_coalescer_pkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  localparam int SECT_NUM    = LINE_BYTES / SECTOR_BYTES,
  localparam int TXN_CNT_W   = $clog2(LANES) + 1,
  localparam int SEC_CNT_W   = $clog2(LANES) + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [LANES-1:0]        reqActive,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  output logic                    txnValid,
  input  logic                    txnReady,
  output logic [ADDR_W-1:0]       txnLineAddr,
  output logic [SECT_NUM-1:0]     txnSectors,
  output logic [1:0]              txnSize,
  output logic [LANES-1:0]        txnLanes,
  output logic                    doneValid,
  output logic [TXN_CNT_W-1:0]    doneTxnCount,
  output logic [SEC_CNT_W-1:0]    doneSectorCount
);
  ctrlStrobe_t strobe;
  logic        pendingEmpty;
  logic        lastTxn;

  warp_coalescer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .txnReady(txnReady),
    .pendingEmpty(pendingEmpty), .lastTxn(lastTxn), .reqReady(reqReady),
    .txnValid(txnValid), .doneValid(doneValid), .strobe(strobe)
  );

  warp_coalescer_dp #(
    .LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqActive(reqActive), .reqAddr(reqAddr),
    .pendingEmpty(pendingEmpty), .lastTxn(lastTxn), .txnLineAddr(txnLineAddr),
    .txnSectors(txnSectors), .txnSize(txnSize), .txnLanes(txnLanes),
    .txnCount(doneTxnCount), .sectorCount(doneSectorCount)
  );
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  localparam int SECT_NUM    = LINE_BYTES / SECTOR_BYTES,
  localparam int TXN_CNT_W   = $clog2(LANES) + 1,
  localparam int SEC_CNT_W   = $clog2(LANES) + 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    reqReady,
  input logic [LANES-1:0]        reqActive,
  input logic                    txnValid,
  input logic                    txnReady,
  input logic [ADDR_W-1:0]       txnLineAddr,
  input logic [SECT_NUM-1:0]     txnSectors,
  input logic [1:0]              txnSize,
  input logic [LANES-1:0]        txnLanes,
  input logic                    doneValid,
  input logic [TXN_CNT_W-1:0]    doneTxnCount,
  input logic [SEC_CNT_W-1:0]    doneSectorCount
);
  logic [LANES-1:0] activeQ;
  logic [LANES-1:0] servedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= '0;
      servedQ <= '0;
    end else if (reqValid && reqReady) begin
      activeQ <= reqActive;
      servedQ <= '0;
    end else if (txnValid && txnReady) begin
      servedQ <= servedQ | txnLanes;
    end
  end

  AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> !reqReady); // R1
  AST_LANE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnLanes & servedQ) == '0) && (txnLanes != '0)); // R3
  AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnLanes & ~activeQ) == '0)); // R6
  AST_SECT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnSectors != '0) && ($countones(txnSectors) <= $countones(txnLanes))); // R4
  AST_SIZE_SMALL: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && txnSize == 2'd0) |-> $countones(txnSectors) == 1); // R5
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> txnValid && $stable(txnLineAddr) && $stable(txnLanes)
      && $stable(txnSectors) && $stable(txnSize)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R9
  AST_DONE_ALL_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (servedQ == activeQ) && (doneSectorCount >= SEC_CNT_W'(doneTxnCount))); // R9
endmodule

bind warp_coalescer warp_coalescer_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqActive(reqActive),
  .txnValid(txnValid), .txnReady(txnReady), .txnLineAddr(txnLineAddr),
  .txnSectors(txnSectors), .txnSize(txnSize), .txnLanes(txnLanes),
  .doneValid(doneValid), .doneTxnCount(doneTxnCount), .doneSectorCount(doneSectorCount)
);

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [31:0]  reqActive = '0;
  logic [1023:0] reqAddr = '0;
  logic         txnValid;
  logic         txnReady = 1'b0;
  logic [31:0]  txnLineAddr;
  logic [3:0]   txnSectors;
  logic [1:0]   txnSize;
  logic [31:0]  txnLanes;
  logic         doneValid;
  logic [5:0]   doneTxnCount;
  logic [6:0]   doneSectorCount;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  logic [31:0] bAddr [32];
  logic [31:0] bActive;
  int          readyPct;

  int          expN;
  int          expSecTot;
  logic [31:0] eLine  [32];
  logic [31:0] eLanes [32];
  logic [3:0]  eSect  [32];
  logic [1:0]  eSize  [32];
  int          obsTxn;
  int          obsSec;

  always #10 clk = ~clk;

  warp_coalescer u_warp_coalescer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqActive(reqActive), .reqAddr(reqAddr), .txnValid(txnValid), .txnReady(txnReady),
    .txnLineAddr(txnLineAddr), .txnSectors(txnSectors), .txnSize(txnSize),
    .txnLanes(txnLanes), .doneValid(doneValid), .doneTxnCount(doneTxnCount),
    .doneSectorCount(doneSectorCount)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] sizeOf(input logic [3:0] m);
    if ($countones(m) <= 1) return 2'd0;
    if (m[3:2] == 2'b00 || m[1:0] == 2'b00) return 2'd1;
    return 2'd2;
  endfunction

  task automatic buildExp();
    logic [31:0] pend = bActive;
    expN = 0;
    expSecTot = 0;
    while (pend != 0) begin
      int lead = 0;
      logic [31:0] lanes = '0;
      logic [3:0]  sect = '0;
      for (int i = 31; i >= 0; i--) if (pend[i]) lead = i;
      for (int i = 0; i < 32; i++) begin
        if (pend[i] && bAddr[i][31:7] == bAddr[lead][31:7]) begin
          lanes[i] = 1'b1;
          sect[bAddr[i][6:5]] = 1'b1;
        end
      end
      eLine[expN]  = {bAddr[lead][31:7], 7'd0};
      eLanes[expN] = lanes;
      eSect[expN]  = sect;
      eSize[expN]  = sizeOf(sect);
      expSecTot += $countones(sect);
      pend = pend & ~lanes;
      expN++;
    end
  endtask

  task automatic runReq(input string name);
    int k = 0;
    bit hold = 0;
    bit seenDone = 0;
    logic [31:0] hLine, hLanes;
    logic [3:0]  hSect;
    logic [1:0]  hSize;
    buildExp();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid  = 1'b1;
    reqActive = bActive;
    for (int i = 0; i < 32; i++) reqAddr[i*32 +: 32] = bAddr[i];
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 600 && !seenDone; c++) begin
      txnReady = (($urandom % 100) < readyPct);
      #1;
      if (doneValid) begin
        seenDone = 1;
        obsTxn = doneTxnCount;
        obsSec = doneSectorCount;
        chk(k == expN, {"R9 txns before done ", name}, k, expN);
        chk(doneTxnCount == 6'(expN), {"R9 txn count ", name}, doneTxnCount, expN);
        chk(doneSectorCount == 7'(expSecTot), {"R9 sector count ", name}, doneSectorCount, expSecTot);
      end else if (txnValid) begin
        chk(!reqReady, {"R1 closed while busy ", name}, reqReady, 0);
        if (hold)
          chk(txnLineAddr == hLine && txnLanes == hLanes && txnSectors == hSect && txnSize == hSize,
              {"R8 hold under stall ", name}, {txnLineAddr, txnLanes}, {hLine, hLanes});
        if (k < expN) begin
          chk(txnLanes == eLanes[k], {"R2 R3 lanes ", name}, txnLanes, eLanes[k]);
          chk(txnLineAddr == eLine[k], {"R2 line ", name}, txnLineAddr, eLine[k]);
          chk(txnSectors == eSect[k], {"R4 sectors ", name}, txnSectors, eSect[k]);
          chk(txnSize == eSize[k], {"R5 size ", name}, txnSize, eSize[k]);
        end else begin
          chk(0, {"R3 extra transaction ", name}, k, expN);
        end
        hold = !txnReady;
        hLine = txnLineAddr; hLanes = txnLanes; hSect = txnSectors; hSize = txnSize;
        if (txnReady) k++;
      end else begin
        hold = 0;
      end
      @(negedge clk);
    end
    txnReady = 1'b0;
    chk(seenDone, {"R9 done seen ", name}, seenDone, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    readyPct = 100;
    repeat (3) @(posedge clk);
    #5;
    chk(!txnValid && !doneValid, "R1 reset idle outputs", {txnValid, doneValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady, "R1 ready after reset", reqReady, 1);

    // R10 aligned contiguous
    for (int i = 0; i < 32; i++) bAddr[i] = 32'h0001_0000 + 32'(i * 4);
    bActive = '1;
    runReq("aligned");
    chk(obsTxn == 1 && obsSec == 4, "R10 aligned gives 1 txn 4 sectors", {obsTxn, obsSec}, {32'd1, 32'd4});

    // R10 unaligned contiguous
    for (int i = 0; i < 32; i++) bAddr[i] = 32'h0001_0040 + 32'(i * 4);
    runReq("unaligned");
    chk(obsTxn == 2, "R10 unaligned gives 2 txns", obsTxn, 2);

    // R10 broadcast, with low address bits set (R2 ignores them)
    for (int i = 0; i < 32; i++) bAddr[i] = 32'h0002_0167;
    runReq("broadcast");
    chk(obsTxn == 1 && obsSec == 1, "R10 broadcast gives 1 txn 1 sector", {obsTxn, obsSec}, {32'd1, 32'd1});

    // R10 large stride, stalled output (R8)
    readyPct = 30;
    for (int i = 0; i < 32; i++) bAddr[i] = 32'h0010_0000 + 32'(i * 16384);
    runReq("stride4096");
    chk(obsTxn == 32 && obsSec == 32, "R10 big stride gives 32 txns", {obsTxn, obsSec}, {32'd32, 32'd32});

    // small stride: two words apart, lanes share lines
    readyPct = 60;
    for (int i = 0; i < 32; i++) bAddr[i] = 32'h0003_0000 + 32'(i * 8);
    runReq("stride2");
    chk(obsTxn == 2, "R10 small stride shares lines", obsTxn, 2);

    // R7 empty request
    bActive = '0;
    runReq("empty");
    chk(obsTxn == 0 && obsSec == 0, "R7 empty request counts", {obsTxn, obsSec}, 0);

    // R6 inactive lanes point at distinct lines
    for (int i = 0; i < 32; i++)
      bAddr[i] = (i % 2 == 0) ? 32'h0004_0000 + 32'(i * 4) : 32'h0080_0000 + 32'(i * 4096);
    bActive = 32'h5555_5555;
    runReq("half active");
    chk(obsTxn == 1 && obsSec == 4, "R6 inactive lanes ignored", {obsTxn, obsSec}, {32'd1, 32'd4});

    // R5 64-byte transaction from sectors 2 and 3
    for (int i = 0; i < 32; i++) bAddr[i] = 32'h0005_0040 + 32'((i % 16) * 4);
    bActive = '1;
    readyPct = 100;
    runReq("upper half");

    // random clustered requests
    for (int t = 0; t < 60; t++) begin
      logic [31:0] base = 32'h0000_4000 + (($urandom % 64) << 7);
      int spread = (t % 3 == 0) ? 128 : ((t % 3 == 1) ? 512 : 4096);
      for (int i = 0; i < 32; i++) bAddr[i] = base + 32'($urandom % spread);
      bActive = (t % 4 == 0) ? '1 : $urandom;
      readyPct = 40 + int'($urandom % 61);
      runReq("random");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule